// File: doc/BRIEF.md
# Boot Certificate Anti-Rollback Checker

This block applies the policy checks to a boot image certificate once its fields have been parsed. It takes the certificate's device-binding serial, its version, and its options byte. It also takes a signature-valid strobe from an external verifier, a revocation enable word, and the device's own serial number. It returns a single accept or boot-fail verdict. Hash and signature arithmetic happen elsewhere. The checks run in a fixed order: serial binding, then version against the stored threshold, then the signature result, then any threshold update.

The block also owns a monotonic revocation threshold. The threshold is held in two redundant copies. Each copy carries a value, a sequence number, a check field and a valid flag. The threshold in force is the valid copy with the newer sequence number. A raise writes the copy that is not current and requests a non-volatile write. Only after the write-done handshake does it mark that copy valid. If a reset arrives during the write, the old value stays in force. A separate reprogramming input is the only way to set the threshold to an arbitrary value, including a lower one.

Top module: `boot_cert_rollback_chk`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `verdict_valid`, `accept`, `boot_fail` and `nv_wr_req` are all 0.
- R2: A non-zero `cert_serial` that differs from `dev_serial` yields a verdict with `boot_fail`=1 and `accept`=0, without waiting for the signature strobe.
- R3: An all-zero `cert_serial` skips the serial comparison. A `cert_serial` equal to `dev_serial` passes it.
- R4: With revocation enabled, a version below the current threshold is rejected (`boot_fail`=1). A version equal to the threshold is accepted.
- R5: Revocation is enabled when any bit of the 32-bit `revoke_word` is 1. When the word is zero, the version is not compared.
- R6: A `sig_done` with `sig_ok`=0 yields `boot_fail`=1 and leaves `thresh_out` unchanged.
- R7: With revocation enabled, `cert_opts` bit 0 set, a valid signature and a version above the threshold, `nv_wr_req` rises and stays high until `nv_wr_done`. The verdict `accept`=1 follows the commit, and `thresh_out` then equals the certificate version.
- R8: Without options bit 0, or with revocation disabled, no write is requested and `thresh_out` is unchanged.
- R9: Outside of reprogramming, `thresh_out` never decreases. A `reprog` pulse loads `reprog_thresh`, whatever its value.
- R10: A reset while `nv_wr_req` is high, before `nv_wr_done`, leaves `thresh_out` at its previous value. A later complete update still succeeds.
- R11: Successive raises alternate between the copies. Across sequence-number wrap-around, the newest committed value stays in force.
- R12: `accept` and `boot_fail` are never both 1, and `verdict_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer (threshold copies are kept) |
| cert_start | input | 1 | Pulse: capture certificate fields and begin checking |
| cert_serial | input | SERIAL_W | Certificate device-binding serial, zero means unbound |
| cert_version | input | VER_W | Certificate version |
| cert_opts | input | 8 | Certificate options, bit 0 requests a threshold raise |
| dev_serial | input | SERIAL_W | This device's serial number |
| revoke_word | input | 32 | Revocation enable, non-zero enables |
| sig_done | input | 1 | Signature verifier result strobe |
| sig_ok | input | 1 | Signature verifier result, 1 means valid |
| nv_wr_done | input | 1 | Non-volatile write completion handshake |
| reprog | input | 1 | Full reprogramming: load threshold from `reprog_thresh` |
| reprog_thresh | input | VER_W | Threshold value loaded by `reprog` |
| verdict_valid | output | 1 | One-cycle pulse when the verdict is ready |
| accept | output | 1 | Certificate accepted |
| boot_fail | output | 1 | Certificate rejected, boot must fail |
| thresh_out | output | VER_W | Threshold currently in force |
| nv_wr_req | output | 1 | Redundant copy write pending |

## Verification
The bench builds the block with SERIAL_W=32, VER_W=16 and SEQ_W=2. With a two-bit sequence number, four raises wrap the counter, so a run of five consecutive updates tests the newer-copy choice across the wrap. The narrow version makes the equal, below and above cases against the threshold easy to set up. The bench also asserts reset in the middle of a pending write, and it reprograms the threshold down, so both the fail-safe path and the only legal decrease are observed at `thresh_out`.

// File: rtl/bcrc_pkg.sv
package bcrc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SER,
    ST_VER,
    ST_SIG,
    ST_WR,
    ST_CMT
  } bcrc_state_t;
endpackage

// File: rtl/bcrc_policy.sv
module bcrc_policy #(
  parameter int SERIAL_W = 128,
  parameter int VER_W    = 64
) (
  input  logic [SERIAL_W-1:0] serial_q,
  input  logic [SERIAL_W-1:0] dev_serial,
  input  logic [VER_W-1:0]    ver_q,
  input  logic                opt_raise,
  input  logic [31:0]         revoke_q,
  input  logic [VER_W-1:0]    thr,
  output logic                ser_fail,
  output logic                ver_fail,
  output logic                raise
);
  logic rev_en;
  always_comb begin
    rev_en   = |revoke_q;
    ser_fail = (|serial_q) && (serial_q != dev_serial);
    ver_fail = rev_en && (ver_q < thr);
    raise    = rev_en && opt_raise && (ver_q > thr);
  end
endmodule

// File: rtl/bcrc_thresh_store.sv
module bcrc_thresh_store #(
  parameter int VER_W = 64,
  parameter int SEQ_W = 8,
  parameter int CHK_W = 8
) (
  input  logic             clk,
  input  logic             reprog,
  input  logic [VER_W-1:0] reprog_val,
  input  logic             wr_start,
  input  logic [VER_W-1:0] wr_val,
  input  logic             wr_commit,
  output logic [VER_W-1:0] thr
);
  localparam int NBANK = 2;
  localparam logic [CHK_W-1:0] CHK_SALT = {CHK_W/2{2'b10}};

  function automatic logic [CHK_W-1:0] fold(input logic [VER_W-1:0] v, input logic [SEQ_W-1:0] s);
    logic [CHK_W-1:0] r;
    r = CHK_SALT;
    for (int k = 0; k < VER_W; k++) r[k % CHK_W] = r[k % CHK_W] ^ v[k];
    for (int k = 0; k < SEQ_W; k++) r[(k + 3) % CHK_W] = r[(k + 3) % CHK_W] ^ s[k];
    return r;
  endfunction

  logic [VER_W-1:0] b_val [NBANK];
  logic [SEQ_W-1:0] b_seq [NBANK];
  logic [CHK_W-1:0] b_chk [NBANK];
  logic             b_vld [NBANK];
  logic             b_ok  [NBANK];

  logic             cur_sel;
  logic             tgt_sel;
  logic             wr_idx;
  logic [SEQ_W-1:0] next_seq;
  logic [SEQ_W-1:0] seq_diff;

  // Bank selection: newest valid copy wins; sequence compared modulo wrap.
  always_comb begin
    seq_diff = b_seq[1] - b_seq[0];
    if (b_ok[0] && b_ok[1]) cur_sel = (seq_diff != '0) && !seq_diff[SEQ_W-1];
    else                    cur_sel = b_ok[1];
    if (b_ok[0] || b_ok[1]) thr = b_val[cur_sel];
    else                    thr = '1;   // fail-safe: reject every revocable image
    tgt_sel  = ~cur_sel;
    next_seq = b_seq[cur_sel] + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_start) wr_idx <= tgt_sel;
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic [VER_W-1:0] val_q;
    logic [SEQ_W-1:0] seq_q;
    logic [CHK_W-1:0] chk_q;
    logic             vld_q;

    always_ff @(posedge clk) begin
      if (reprog) begin
        val_q <= reprog_val;
        seq_q <= SEQ_W'(1);
        chk_q <= fold(reprog_val, SEQ_W'(1));
        vld_q <= (i == 0);
      end else if (wr_start && (tgt_sel == 1'(i))) begin
        val_q <= wr_val;
        seq_q <= next_seq;
        chk_q <= fold(wr_val, next_seq);
        vld_q <= 1'b0;
      end else if (wr_commit && (wr_idx == 1'(i))) begin
        vld_q <= 1'b1;
      end
    end

    assign b_val[i] = val_q;
    assign b_seq[i] = seq_q;
    assign b_chk[i] = chk_q;
    assign b_vld[i] = vld_q;
    assign b_ok[i]  = vld_q && (chk_q == fold(val_q, seq_q));
  end
endmodule

// File: rtl/boot_cert_rollback_chk.sv
module boot_cert_rollback_chk
  import bcrc_pkg::*;
#(
  parameter int SERIAL_W = 128,
  parameter int VER_W    = 64,
  parameter int SEQ_W    = 8,
  parameter int CHK_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cert_start,
  input  logic [SERIAL_W-1:0] cert_serial,
  input  logic [VER_W-1:0]    cert_version,
  input  logic [7:0]          cert_opts,
  input  logic [SERIAL_W-1:0] dev_serial,
  input  logic [31:0]         revoke_word,
  input  logic                sig_done,
  input  logic                sig_ok,
  input  logic                nv_wr_done,
  input  logic                reprog,
  input  logic [VER_W-1:0]    reprog_thresh,
  output logic                verdict_valid,
  output logic                accept,
  output logic                boot_fail,
  output logic [VER_W-1:0]    thresh_out,
  output logic                nv_wr_req
);
  bcrc_state_t         state;
  logic [SERIAL_W-1:0] serial_q;
  logic [VER_W-1:0]    ver_q;
  logic                opt_q;
  logic [31:0]         revoke_q;
  logic [VER_W-1:0]    thr;
  logic                ser_fail, ver_fail, raise;
  logic                wr_start, wr_commit;

  always_ff @(posedge clk) begin
    if (state == ST_IDLE && cert_start) begin
      serial_q <= cert_serial;
      ver_q    <= cert_version;
      opt_q    <= cert_opts[0];
      revoke_q <= revoke_word;
    end
  end

  bcrc_policy #(.SERIAL_W(SERIAL_W), .VER_W(VER_W)) u_policy (
    .serial_q  (serial_q),
    .dev_serial(dev_serial),
    .ver_q     (ver_q),
    .opt_raise (opt_q),
    .revoke_q  (revoke_q),
    .thr       (thr),
    .ser_fail  (ser_fail),
    .ver_fail  (ver_fail),
    .raise     (raise)
  );

  assign wr_start  = !rst && !reprog && (state == ST_SIG) && sig_done && sig_ok && raise;
  assign wr_commit = !rst && !reprog && (state == ST_WR) && nv_wr_done;

  bcrc_thresh_store #(.VER_W(VER_W), .SEQ_W(SEQ_W), .CHK_W(CHK_W)) u_store (
    .clk       (clk),
    .reprog    (reprog),
    .reprog_val(reprog_thresh),
    .wr_start  (wr_start),
    .wr_val    (ver_q),
    .wr_commit (wr_commit),
    .thr       (thr)
  );

  always_ff @(posedge clk) thresh_out <= thr;

  always_ff @(posedge clk) begin
    if (rst || reprog) begin
      state         <= ST_IDLE;
      verdict_valid <= 1'b0;
      accept        <= 1'b0;
      boot_fail     <= 1'b0;
      nv_wr_req     <= 1'b0;
    end else begin
      verdict_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (cert_start) begin
          accept    <= 1'b0;
          boot_fail <= 1'b0;
          state     <= ST_SER;
        end
        ST_SER: if (ser_fail) begin
          boot_fail <= 1'b1; verdict_valid <= 1'b1; state <= ST_IDLE;
        end else state <= ST_VER;
        ST_VER: if (ver_fail) begin
          boot_fail <= 1'b1; verdict_valid <= 1'b1; state <= ST_IDLE;
        end else state <= ST_SIG;
        ST_SIG: if (sig_done) begin
          if (!sig_ok) begin
            boot_fail <= 1'b1; verdict_valid <= 1'b1; state <= ST_IDLE;
          end else if (raise) begin
            nv_wr_req <= 1'b1; state <= ST_WR;
          end else begin
            accept <= 1'b1; verdict_valid <= 1'b1; state <= ST_IDLE;
          end
        end
        ST_WR: if (nv_wr_done) begin
          nv_wr_req <= 1'b0; state <= ST_CMT;
        end
        ST_CMT: begin
          accept <= 1'b1; verdict_valid <= 1'b1; state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bcrc_checker.sv
module bcrc_checker #(
  parameter int VER_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             reprog,
  input logic             verdict_valid,
  input logic             accept,
  input logic             boot_fail,
  input logic             nv_wr_req,
  input logic             nv_wr_done,
  input logic [VER_W-1:0] thresh_out
);
  // R12
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(accept && boot_fail));
  // R12
  verdict_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |=> !verdict_valid);
  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst || reprog)
    (nv_wr_req && !nv_wr_done) |=> nv_wr_req);
  // R9
  thr_mono_chk: assert property (@(posedge clk) disable iff (rst || reprog)
    (!$past(reprog) && !$past(reprog, 2)) |-> (thresh_out >= $past(thresh_out)));
  // R7
  wr_no_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    nv_wr_req |-> !verdict_valid);
endmodule

bind boot_cert_rollback_chk bcrc_checker #(.VER_W(VER_W)) u_bcrc_chk (
  .clk          (clk),
  .rst          (rst),
  .reprog       (reprog),
  .verdict_valid(verdict_valid),
  .accept       (accept),
  .boot_fail    (boot_fail),
  .nv_wr_req    (nv_wr_req),
  .nv_wr_done   (nv_wr_done),
  .thresh_out   (thresh_out)
);

// File: tb/boot_cert_rollback_chk_tb_top.sv
module boot_cert_rollback_chk_tb_top;
  localparam int SW = 32;
  localparam int VW = 16;
  localparam logic [SW-1:0] DEV = 32'hCAFE_0123;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cert_start = 1'b0;
  logic [SW-1:0] cert_serial = '0;
  logic [VW-1:0] cert_version = '0;
  logic [7:0]    cert_opts = '0;
  logic [31:0]   revoke_word = '0;
  logic          sig_done = 1'b0;
  logic          sig_ok = 1'b0;
  logic          nv_wr_done = 1'b0;
  logic          reprog = 1'b1;
  logic [VW-1:0] reprog_thresh = 16'd5;
  logic          verdict_valid, accept, boot_fail, nv_wr_req;
  logic [VW-1:0] thresh_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  boot_cert_rollback_chk #(.SERIAL_W(SW), .VER_W(VW), .SEQ_W(2), .CHK_W(8)) dut_i (
    .clk(clk), .rst(rst), .cert_start(cert_start), .cert_serial(cert_serial),
    .cert_version(cert_version), .cert_opts(cert_opts), .dev_serial(DEV),
    .revoke_word(revoke_word), .sig_done(sig_done), .sig_ok(sig_ok),
    .nv_wr_done(nv_wr_done), .reprog(reprog), .reprog_thresh(reprog_thresh),
    .verdict_valid(verdict_valid), .accept(accept), .boot_fail(boot_fail),
    .thresh_out(thresh_out), .nv_wr_req(nv_wr_req)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one certificate; services the write handshake after two cycles.
  task automatic run_cert(input logic [SW-1:0] ser, input logic [VW-1:0] ver,
                          input logic [7:0] opts, input logic [31:0] rev, input bit sok,
                          output bit acc, output bit bf, output bit saw_wr);
    int wr_wait = 0;
    bit got = 0;
    bit both = 0;
    saw_wr = 0; acc = 0; bf = 0;
    @(negedge clk);
    cert_serial = ser; cert_version = ver; cert_opts = opts; revoke_word = rev;
    sig_done = 1'b1; sig_ok = sok; cert_start = 1'b1;
    @(negedge clk);
    cert_start = 1'b0;
    for (int c = 0; c < 300 && !got; c++) begin
      nv_wr_done = 1'b0;
      if (accept && boot_fail) both = 1;
      if (verdict_valid) begin
        got = 1; acc = accept; bf = boot_fail;
      end else begin
        if (nv_wr_req) begin
          saw_wr = 1;
          if (wr_wait == 2) nv_wr_done = 1'b1;
          wr_wait++;
        end
        @(negedge clk);
      end
    end
    sig_done = 1'b0;
    check(got, "R12 verdict arrives", got, 1);
    check(!both, "R12 accept and boot_fail exclusive", both, 0);
    @(negedge clk);
    check(!verdict_valid, "R12 verdict one-cycle pulse", verdict_valid, 0);
  endtask

  task automatic t_reset();
    check(!verdict_valid && !accept && !boot_fail && !nv_wr_req, "R1 outputs idle after reset",
          {verdict_valid, accept, boot_fail, nv_wr_req}, 0);
    check(thresh_out == 5, "R9 reprog load", thresh_out, 5);
  endtask

  task automatic t_serial();
    bit a, b, w;
    run_cert(32'h0000_1234, 16'd9, 8'h00, 32'h1, 1'b1, a, b, w);
    check(b && !a, "R2 serial mismatch rejects", {a, b}, 1);
    run_cert('0, 16'd5, 8'h00, 32'h1, 1'b1, a, b, w);
    check(a && !b, "R3 zero serial skips check", {a, b}, 2);
    run_cert(DEV, 16'd6, 8'h00, 32'h1, 1'b1, a, b, w);
    check(a && !b, "R3 matching serial passes", {a, b}, 2);
  endtask

  task automatic t_version();
    bit a, b, w;
    run_cert('0, 16'd4, 8'h00, 32'h1, 1'b1, a, b, w);
    check(b && !a, "R4 version below threshold rejected", {a, b}, 1);
    run_cert('0, 16'd5, 8'h00, 32'h1, 1'b1, a, b, w);
    check(a && !b, "R4 version equal threshold accepted", {a, b}, 2);
    run_cert('0, 16'd1, 8'h00, 32'h0, 1'b1, a, b, w);
    check(a && !b, "R5 revocation off skips version", {a, b}, 2);
    run_cert('0, 16'd2, 8'h00, 32'h8000_0000, 1'b1, a, b, w);
    check(b && !a, "R5 top bit alone enables revocation", {a, b}, 1);
  endtask

  task automatic t_sig_and_noupdate();
    bit a, b, w;
    run_cert('0, 16'd9, 8'h01, 32'h1, 1'b0, a, b, w);
    check(b && !a && !w, "R6 bad signature fails without write", {a, b, w}, 1);
    repeat (2) @(negedge clk);
    check(thresh_out == 5, "R6 threshold unchanged", thresh_out, 5);
    run_cert('0, 16'd9, 8'h00, 32'h1, 1'b1, a, b, w);
    check(a && !w, "R8 option bit clear, no write", {a, w}, 2);
    run_cert('0, 16'd9, 8'h01, 32'h0, 1'b1, a, b, w);
    check(a && !w, "R8 revocation off, no write", {a, w}, 2);
    repeat (2) @(negedge clk);
    check(thresh_out == 5, "R8 threshold unchanged", thresh_out, 5);
  endtask

  task automatic t_raise();
    bit a, b, w;
    run_cert('0, 16'd9, 8'h01, 32'h1, 1'b1, a, b, w);
    check(a && w, "R7 raise accepted with write", {a, w}, 3);
    repeat (2) @(negedge clk);
    check(thresh_out == 9, "R7 threshold raised", thresh_out, 9);
    run_cert('0, 16'd7, 8'h01, 32'h1, 1'b1, a, b, w);
    check(b && !w, "R9 older version cannot lower", {b, w}, 2);
    repeat (2) @(negedge clk);
    check(thresh_out == 9, "R9 threshold kept", thresh_out, 9);
  endtask

  task automatic t_interrupt();
    bit a, b, w;
    bit seen = 0;
    @(negedge clk);
    cert_serial = '0; cert_version = 16'd12; cert_opts = 8'h01; revoke_word = 32'h1;
    sig_done = 1'b1; sig_ok = 1'b1; cert_start = 1'b1;
    @(negedge clk);
    cert_start = 1'b0;
    for (int c = 0; c < 20 && !seen; c++) begin
      if (nv_wr_req) seen = 1; else @(negedge clk);
    end
    check(seen, "R10 write request raised", seen, 1);
    rst = 1'b1; sig_done = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!nv_wr_req && !verdict_valid, "R1 idle after reset", {nv_wr_req, verdict_valid}, 0);
    repeat (2) @(negedge clk);
    check(thresh_out == 9, "R10 interrupted update keeps old", thresh_out, 9);
    run_cert('0, 16'd12, 8'h01, 32'h1, 1'b1, a, b, w);
    repeat (2) @(negedge clk);
    check(a && thresh_out == 12, "R10 retry after interrupt", thresh_out, 12);
  endtask

  task automatic t_wrap();
    bit a, b, w;
    for (int k = 13; k <= 17; k++) begin
      run_cert('0, VW'(k), 8'h01, 32'h1, 1'b1, a, b, w);
      repeat (2) @(negedge clk);
      check(a && w && thresh_out == VW'(k), "R11 newest copy in force", thresh_out, k);
    end
  endtask

  task automatic t_reprog();
    bit a, b, w;
    @(negedge clk);
    reprog = 1'b1; reprog_thresh = 16'd2;
    @(negedge clk);
    reprog = 1'b0;
    repeat (2) @(negedge clk);
    check(thresh_out == 2, "R9 reprog lowers threshold", thresh_out, 2);
    run_cert('0, 16'd3, 8'h00, 32'h1, 1'b1, a, b, w);
    check(a && !b, "R9 version accepted after reprog", {a, b}, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    reprog = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_serial();
    t_version();
    t_sig_and_noupdate();
    t_raise();
    t_interrupt();
    t_wrap();
    t_reprog();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule